// File: doc/BRIEF.md
# Per-Channel Short-Circuit Shutoff Timer

This block holds one shutoff timer for each output channel of a multi-channel low-side driver. A channel's timer runs while that channel reports that its current limit is active. If the limit is still active when the shutoff delay runs out, the channel's short flag is latched and a one-cycle trip pulse tells the controller to clear the channel's command bit. The delay is long, typically 40 ms, so that lamp inrush currents do not trip the channel. A limit that drops before the delay runs out resets the timer, so short inrush bursts never add up.

A latched short flag is cleared in only two ways: the controller writes "off" to that channel during a transfer, or the device enters standby. Standby also stops all timing, because the oscillator is off. In two test modes an external control pin clocks the timers in place of the oscillator, so that a tester can reach the delay in a few pulses. The block takes no part in sensing current. It receives the current-limit indications already sampled into its clock domain.

Top module: `short_shutoff_timer`

## Requirements
- R1: Synchronous reset, active high, clears every timer. After reset every bit of `short_flag` and `trip` is 0.
- R2: When a channel's `ilim` bit stays 1 and its flag is clear, each advance pulse counts once. On the clock edge that samples the TERM-th advance, `trip` for that channel is 1 and its `short_flag` becomes 1. Both show up in the register outputs that follow that edge.
- R3: If `ilim` for a channel is 0 at any edge before expiry, that channel's count returns to zero, and a later limit needs TERM fresh advances.
- R4: `trip` is high for exactly one cycle per expiry. `short_flag` then stays 1 whatever `ilim` does, and no new trip occurs until the flag is cleared.
- R5: An edge with `latch_wr`=1 and `wr_data` bit = 1 (1 means off) clears that channel's flag and count. This clear takes priority over an expiry in the same cycle, which then produces no trip. A `wr_data` bit of 0, or any data while `latch_wr`=0, leaves the flag unchanged.
- R6: An edge with `standby`=1 clears all flags and counts. While standby is 1, advance pulses of every source are ignored.
- R7: With `test_sel`=2'b01 the timers advance on each rising edge of `tr_pin` seen at the clock, and `osc_tick` is ignored.
- R8: With `test_sel`=2'b10 the timers advance on each rising edge of `en_pin` seen at the clock, and `osc_tick` is ignored. The codes 2'b00 and 2'b11 select `osc_tick`.
- R9: Channels are independent. One channel's limit, write bit or trip does not change another channel's count or flag.
- R10: TERM = SHUTOFF_NS / TICK_PERIOD_NS, with a floor of 2. The defaults (10 us tick, 40 ms delay) give 4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| osc_tick | input | 1 | One-cycle oscillator tick pulse |
| ilim | input | NUM_CH | Per-channel current-limit active indication |
| latch_wr | input | 1 | Controller is writing the command latches (transfer) |
| wr_data | input | NUM_CH | Command data being written, 1 = channel off |
| standby | input | 1 | Standby mode: clear flags, stop timing |
| test_sel | input | 2 | Advance source: 00/11 oscillator, 01 tr_pin edges, 10 en_pin edges |
| tr_pin | input | 1 | Synchronised transfer control pin, test clock 1 |
| en_pin | input | 1 | Synchronised enable control pin, test clock 2 |
| trip | output | NUM_CH | One-cycle pulse: channel shut off, clear its command bit |
| short_flag | output | NUM_CH | Latched short-circuit flag per channel |

## Verification
Every result of this block is registered once. The inputs sampled at an edge, including a same-cycle test-pin edge, show up in `trip` and `short_flag` just after that edge, and there is no further latency. The bench drives its inputs on the falling clock edge. Just after each rising edge it advances its own model by one step from the inputs it drove, then compares both outputs. A trip is therefore checked in exactly the cycle of the TERM-th advance, and a clear in exactly the cycle of the write or standby. Directed checks at the expiry boundary (TERM-1 advances against TERM) and at a clear that meets an expiry in the same cycle pin those timings down explicitly.

// File: rtl/short_timer_pkg.sv
package short_timer_pkg;

    // Source that advances the shutoff timers
    typedef enum logic [1:0] {
        SRC_OSC     = 2'b00,
        SRC_TR_EDGE = 2'b01,
        SRC_EN_EDGE = 2'b10,
        SRC_OSC_ALT = 2'b11
    } adv_src_e;

    // Per-channel control bundle fed to each timer
    typedef struct packed {
        logic limit;    // current limit active
        logic wr_off;   // command write of "off" to this channel
        logic standby;  // standby clear
        logic adv;      // advance pulse
    } chan_ctl_t;

    // Terminal advance count derived from the two periods, floor of 2
    function automatic int unsigned term_ticks(input int unsigned tick_ns,
                                               input int unsigned delay_ns);
        int unsigned q;
        q = delay_ns / tick_ns;
        return (q < 2) ? 2 : q;
    endfunction

endpackage

// File: rtl/adv_source.sv
module adv_source
    import short_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     osc_tick,
    input  logic     tr_pin,
    input  logic     en_pin,
    input  logic     standby,
    input  adv_src_e sel,
    output logic     adv
);

    logic tr_q;
    logic en_q;
    logic tr_rise;
    logic en_rise;
    logic raw_adv;

    always_ff @(posedge clk) begin
        if (rst) begin
            tr_q <= 1'b0;
            en_q <= 1'b0;
        end else begin
            tr_q <= tr_pin;
            en_q <= en_pin;
        end
    end

    assign tr_rise = tr_pin & ~tr_q;
    assign en_rise = en_pin & ~en_q;

    always_comb begin
        unique case (sel)
            SRC_TR_EDGE: raw_adv = tr_rise;
            SRC_EN_EDGE: raw_adv = en_rise;
            SRC_OSC,
            SRC_OSC_ALT: raw_adv = osc_tick;
            default:     raw_adv = osc_tick;
        endcase
    end

    // oscillator and test clocks are stopped in standby
    assign adv = raw_adv & ~standby;

    // R6: no advance while in standby
    assert_no_adv_in_standby_R6: assert property (@(posedge clk) disable iff (rst)
        standby |-> !adv);

    // R7: in tr-edge mode an advance needs tr_pin high
    assert_tr_mode_needs_pin_R7: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_TR_EDGE && adv) |-> tr_pin);

    // R8: in en-edge mode an advance needs en_pin high
    assert_en_mode_needs_pin_R8: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_EN_EDGE && adv) |-> en_pin);

endmodule

// File: rtl/chan_timer.sv
module chan_timer
    import short_timer_pkg::*;
#(
    parameter int unsigned TERM = 4000
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_ctl_t ctl,
    output logic      trip_o,
    output logic      flag_o
);

    localparam int unsigned CNT_W = $clog2(TERM + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);

    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             trip;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
            trip <= 1'b0;
        end else begin
            trip <= 1'b0;
            if (ctl.standby) begin
                cnt  <= '0;
                flag <= 1'b0;
            end else if (ctl.wr_off) begin
                cnt  <= '0;
                flag <= 1'b0;
            end else if (flag) begin
                cnt  <= '0;
            end else if (!ctl.limit) begin
                cnt  <= '0;
            end else if (ctl.adv) begin
                if (cnt == LAST) begin
                    cnt  <= '0;
                    flag <= 1'b1;
                    trip <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign trip_o = trip;
    assign flag_o = flag;

    // R2: counter never passes the terminal value
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(TERM));

    // R3: a dropped limit leaves a zero count
    assert_drop_clears_count_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl.limit |=> (cnt == '0));

    // R4: trip lasts a single cycle
    assert_trip_single_R4: assert property (@(posedge clk) disable iff (rst)
        trip |=> !trip);

    // R4: flag only rises together with a trip
    assert_flag_rise_with_trip_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> trip);

    // R5: write-off leaves the flag and count clear
    assert_wr_off_clears_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_off |=> (!flag && !trip && cnt == '0));

    // R5/R6: the flag falls only after a write-off or standby
    assert_flag_fall_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(ctl.wr_off || ctl.standby));

    // R6: standby clears flag and count
    assert_standby_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.standby |=> (!flag && cnt == '0));

endmodule

// File: rtl/short_shutoff_timer.sv
module short_shutoff_timer
    import short_timer_pkg::*;
#(
    parameter int unsigned NUM_CH         = 8,
    parameter int unsigned TICK_PERIOD_NS = 10_000,
    parameter int unsigned SHUTOFF_NS     = 40_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic [NUM_CH-1:0] ilim,
    input  logic              latch_wr,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic              standby,
    input  logic [1:0]        test_sel,
    input  logic              tr_pin,
    input  logic              en_pin,
    output logic [NUM_CH-1:0] trip,
    output logic [NUM_CH-1:0] short_flag
);

    // R10: terminal count from the tick period and the shutoff delay
    localparam int unsigned TERM = term_ticks(TICK_PERIOD_NS, SHUTOFF_NS);

    logic     adv;
    adv_src_e sel;

    assign sel = adv_src_e'(test_sel);

    adv_source u_adv (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .tr_pin   (tr_pin),
        .en_pin   (en_pin),
        .standby  (standby),
        .sel      (sel),
        .adv      (adv)
    );

    // R9: one independent timer per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        chan_ctl_t ctl;

        assign ctl.limit   = ilim[ch];
        assign ctl.wr_off  = latch_wr & wr_data[ch];
        assign ctl.standby = standby;
        assign ctl.adv     = adv;

        chan_timer #(
            .TERM (TERM)
        ) u_timer (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .trip_o (trip[ch]),
            .flag_o (short_flag[ch])
        );
    end

    // R1: outputs are clear in the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (trip == '0 && short_flag == '0));

    // R4: every trip bit lands on a set flag
    assert_trip_implies_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (trip & ~short_flag) == '0);

endmodule

// File: tb/test_short_shutoff_timer.sv
module test_short_shutoff_timer;

    localparam int NCH  = 8;
    localparam int TERM = 8;   // 8000 ns / 1000 ns

    logic           clk = 1'b0;
    logic           rst;
    logic           osc_tick;
    logic [NCH-1:0] ilim;
    logic           latch_wr;
    logic [NCH-1:0] wr_data;
    logic           standby;
    logic [1:0]     test_sel;
    logic           tr_pin;
    logic           en_pin;
    logic [NCH-1:0] trip;
    logic [NCH-1:0] short_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // bench model state
    int             m_cnt [NCH];
    logic [NCH-1:0] m_flag;
    logic [NCH-1:0] m_trip;
    logic           m_tr_q;
    logic           m_en_q;

    always #10 clk = ~clk;   // 50 MHz

    short_shutoff_timer #(
        .NUM_CH         (NCH),
        .TICK_PERIOD_NS (1000),
        .SHUTOFF_NS     (8000)
    ) i_short_shutoff_timer (
        .clk        (clk),
        .rst        (rst),
        .osc_tick   (osc_tick),
        .ilim       (ilim),
        .latch_wr   (latch_wr),
        .wr_data    (wr_data),
        .standby    (standby),
        .test_sel   (test_sel),
        .tr_pin     (tr_pin),
        .en_pin     (en_pin),
        .trip       (trip),
        .short_flag (short_flag)
    );

    function automatic logic model_adv();
        logic a;
        case (test_sel)
            2'b01:   a = tr_pin & ~m_tr_q;
            2'b10:   a = en_pin & ~m_en_q;
            default: a = osc_tick;
        endcase
        return a & ~standby;
    endfunction

    task automatic model_step();
        logic a;
        a = model_adv();
        for (int i = 0; i < NCH; i++) begin
            m_trip[i] = 1'b0;
            if (rst || standby || (latch_wr && wr_data[i])) begin
                m_cnt[i] = 0;
                m_flag[i] = 1'b0;
            end else if (m_flag[i] || !ilim[i]) begin
                m_cnt[i] = 0;
            end else if (a) begin
                if (m_cnt[i] == TERM - 1) begin
                    m_cnt[i] = 0;
                    m_flag[i] = 1'b1;
                    m_trip[i] = 1'b1;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
        m_tr_q = rst ? 1'b0 : tr_pin;
        m_en_q = rst ? 1'b0 : en_pin;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        model_step();
        checks++;
        if (short_flag !== m_flag || trip !== m_trip) begin
            fails++;
            $display("FAIL %s: flag=%h trip=%h expected flag=%h trip=%h",
                     cur_req, short_flag, trip, m_flag, m_trip);
        end
        @(negedge clk);
    endtask

    task automatic expect_flag(input int ch, input logic val, input string req);
        checks++;
        if (short_flag[ch] !== val) begin
            fails++;
            $display("FAIL %s: ch%0d flag=%b expected %b", req, ch, short_flag[ch], val);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            osc_tick = 1'b1; cyc();
            osc_tick = 1'b0; cyc(); cyc();
        end
    endtask

    task automatic pin_pulses(input bit use_tr, input int n);
        for (int k = 0; k < n; k++) begin
            if (use_tr) tr_pin = 1'b1; else en_pin = 1'b1;
            cyc(); cyc();
            if (use_tr) tr_pin = 1'b0; else en_pin = 1'b0;
            cyc();
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        m_flag = '0; m_trip = '0; m_tr_q = 0; m_en_q = 0;
        rst = 1; osc_tick = 0; ilim = '0; latch_wr = 0; wr_data = '0;
        standby = 0; test_sel = 2'b00; tr_pin = 0; en_pin = 0;
        @(negedge clk);

        // R1: reset state
        cur_req = "R1";
        cyc(); cyc();
        rst = 0;
        cyc();
        expect_flag(0, 1'b0, "R1");

        // R2/R10: TERM-1 ticks no trip, TERM-th trips
        cur_req = "R2";
        ilim = 8'h01;
        ticks(TERM - 1);
        expect_flag(0, 1'b0, "R2");
        osc_tick = 1'b1; cyc(); osc_tick = 1'b0;
        expect_flag(0, 1'b1, "R10");

        // R4: flag holds with limit on or off, no repeat trip
        cur_req = "R4";
        ticks(TERM + 2);
        ilim = 8'h00;
        ticks(3);
        expect_flag(0, 1'b1, "R4");

        // R5: bit 0 write and strobe-less data ignored, then write-off clears
        cur_req = "R5";
        latch_wr = 1; wr_data = 8'hFE; cyc();
        latch_wr = 0; wr_data = 8'hFF; cyc();
        expect_flag(0, 1'b1, "R5");
        latch_wr = 1; wr_data = 8'h01; cyc(); latch_wr = 0; wr_data = '0;
        expect_flag(0, 1'b0, "R5");

        // R3: limit drop before expiry restarts the count
        cur_req = "R3";
        ilim = 8'h02;
        ticks(TERM - 2);
        ilim = 8'h00; cyc();
        ilim = 8'h02;
        ticks(TERM - 1);
        expect_flag(1, 1'b0, "R3");
        ticks(1);
        expect_flag(1, 1'b1, "R3");

        // R5: write-off meets expiry in the same cycle
        cur_req = "R5";
        ilim = 8'h04;
        ticks(TERM - 1);
        osc_tick = 1; latch_wr = 1; wr_data = 8'h04; cyc();
        osc_tick = 0; latch_wr = 0; wr_data = '0;
        expect_flag(2, 1'b0, "R5");

        // R6: standby clears all flags and ignores ticks
        cur_req = "R6";
        ilim = 8'h06;
        ticks(TERM);
        standby = 1;
        ticks(TERM + 1);
        expect_flag(1, 1'b0, "R6");
        standby = 0;
        ticks(TERM - 1);
        expect_flag(2, 1'b0, "R6");
        ticks(1);

        // R7: tr_pin edges clock, osc ignored
        cur_req = "R7";
        latch_wr = 1; wr_data = 8'hFF; cyc(); latch_wr = 0;
        ilim = 8'h08; test_sel = 2'b01;
        ticks(TERM + 1);
        expect_flag(3, 1'b0, "R7");
        pin_pulses(1, TERM);
        expect_flag(3, 1'b1, "R7");

        // R8: en_pin edges clock
        cur_req = "R8";
        ilim = 8'h10; test_sel = 2'b10;
        pin_pulses(1, TERM + 1);
        ticks(2);
        expect_flag(4, 1'b0, "R8");
        pin_pulses(0, TERM);
        expect_flag(4, 1'b1, "R8");

        // R9: random mix across channels
        cur_req = "R9";
        test_sel = 2'b00;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(15) == 0) ilim[$urandom_range(NCH - 1)] ^= 1'b1;
            osc_tick = ($urandom_range(2) == 0);
            latch_wr = ($urandom_range(19) == 0);
            wr_data  = 8'($urandom);
            standby  = ($urandom_range(99) == 0);
            if ($urandom_range(199) == 0) test_sel = 2'($urandom);
            if ($urandom_range(3) == 0) tr_pin = ~tr_pin;
            if ($urandom_range(3) == 0) en_pin = ~en_pin;
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule